// File: doc/BRIEF.md
# Stuck State-Machine Watchdog

This block supervises a group of controller state machines, each of which reports one flag that is high whenever it is outside its idle state. For every machine a counter measures, in ticks of a slow timebase, how long the flag has stayed high without a break. A machine whose flag stays high for more ticks than the configured limit is declared stuck. With the default settings the tick is a one-second strobe and the limit is five ticks, so the threshold is five seconds.

A stuck machine leads to one of two actions, picked by a configuration bit. The block can issue a fixed-width reset pulse, after which every counter starts again from zero. It can instead raise an interrupt, with a sticky per-machine status word that records which machine timed out. Software clears that word with a write-one-to-clear strobe. The monitor does anything only when two conditions hold: a board-level strap pin was high while reset was applied, and the software enable bit is set.

Top module: `sm_stall_watchdog`

## Requirements
- R1: The strap pin level is captured while `rst` is high, and `rst` must stay high for at least 3 clocks. Once `rst` is low, changes on `strap_in` have no effect until the next reset.
- R2: If the captured strap is low, every counter stays at zero, and `reset_pulse_o`, `irq_o` and every bit of `stuck_status_o` stay low whatever the other inputs do.
- R3: While `cfg_enable` is 0 every counter is held at zero and no detection occurs. After `cfg_enable` rises, a busy machine needs a full `LIMIT_TICKS`+1 ticks before it is declared stuck.
- R4: A machine counts the clocks on which `tick` is 1 while its `busy` bit stays 1. It is declared stuck on its (`LIMIT_TICKS`+1)-th such tick. The resulting action becomes visible on the outputs two rising edges after the edge that samples that tick.
- R5: A busy bit that is 0 for even one clock clears that machine's count, so only uninterrupted busy time is measured.
- R6: In interrupt mode (`cfg_mode` = 0) a detection on machine i sets bit i of `stuck_status_o`. `irq_o` equals the OR of all status bits.
- R7: A status bit stays set until a clock on which `status_clr_we` = 1 and bit i of `status_clr_mask` = 1. Mask bits that are 0 leave their status bits unchanged. If a detection and a clear reach the same bit on the same clock, the bit stays set.
- R8: One uninterrupted busy stretch produces at most one detection in interrupt mode. Clearing the status while the machine stays busy does not set the bit again.
- R9: In reset mode (`cfg_mode` = 1) a detection drives `reset_pulse_o` high for exactly `PULSE_CYCLES` clocks and leaves `stuck_status_o` and `irq_o` unchanged.
- R10: While the reset pulse is high, all counters are held at zero. A machine that is still busy after the pulse needs another full `LIMIT_TICKS`+1 ticks before it triggers again.
- R11: Machines are timed independently. Machines that time out on the same tick all have their status bits set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, also the strap capture window |
| strap_in | input | 1 | Bootstrap pin that enables the feature |
| cfg_enable | input | 1 | Software enable bit |
| cfg_mode | input | 1 | Action select: 0 interrupt, 1 reset pulse |
| status_clr_we | input | 1 | Write strobe for clearing status bits |
| status_clr_mask | input | NUM_SM | Write-one-to-clear mask for the status word |
| tick | input | 1 | One-clock timebase strobe |
| busy | input | NUM_SM | Per-machine non-idle flags |
| reset_pulse_o | output | 1 | Reset request pulse |
| irq_o | output | 1 | Interrupt request, level |
| stuck_status_o | output | NUM_SM | Sticky record of machines that timed out |

## Verification
The bench builds the block with four machines, a limit of three ticks and a three-clock reset pulse. These values keep every threshold crossing short enough to step tick by tick. At these sizes the bench can place a detection and a clear write on the same clock, time the first and last pulse cycles against the count, and watch a machine time out again after a pulse. Ticks are driven one at a time. This makes the last tick that stays silent and the first tick that detects visible as separate observations for each scenario.

// File: rtl/smw_pkg.sv
package smw_pkg;
  typedef enum logic {
    SMW_ACT_IRQ   = 1'b0,
    SMW_ACT_RESET = 1'b1
  } smw_action_e;
endpackage

// File: rtl/smw_strap_latch.sv
// Brings the strap pin into the clock domain and freezes its value at the end of reset.
module smw_strap_latch (
  input  logic clk,
  input  logic rst,
  input  logic strap_in,
  output logic strap_ok
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk) begin
    meta_q <= strap_in;
    sync_q <= meta_q;
  end

  always_ff @(posedge clk) begin
    if (rst) strap_ok <= sync_q;
  end
endmodule

// File: rtl/smw_stall_counter.sv
// Counts ticks of uninterrupted busy time for one machine and saturates above the limit.
module smw_stall_counter #(
  parameter int LIMIT_TICKS = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic clear,
  input  logic busy,
  input  logic tick,
  output logic hit
);
  localparam int CNT_W = $clog2(LIMIT_TICKS + 2);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT_TICKS);
  localparam logic [CNT_W-1:0] SAT  = CNT_W'(LIMIT_TICKS + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             live;

  assign live = arm && busy && !clear;

  always_ff @(posedge clk) begin
    if (rst || !live) begin
      cnt_q <= '0;
    end else if (tick && cnt_q != SAT) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) hit <= 1'b0;
    else     hit <= live && tick && (cnt_q == LAST);
  end
endmodule

// File: rtl/smw_action_unit.sv
// Turns detections into a reset pulse or a sticky status plus interrupt.
module smw_action_unit
  import smw_pkg::*;
#(
  parameter int NUM_SM       = 8,
  parameter int PULSE_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strap_ok,
  input  smw_action_e       mode,
  input  logic [NUM_SM-1:0] hits,
  input  logic              clr_we,
  input  logic [NUM_SM-1:0] clr_mask,
  output logic [NUM_SM-1:0] status_o,
  output logic              irq_o,
  output logic              pulse_o
);
  localparam int PW = $clog2(PULSE_CYCLES + 1);
  localparam logic [PW-1:0] PLOAD = PW'(PULSE_CYCLES);

  logic [PW-1:0]     pcnt_q;
  logic [NUM_SM-1:0] status_d;
  logic [NUM_SM-1:0] clr_eff;
  logic [NUM_SM-1:0] set_eff;
  logic              fire;

  assign clr_eff = clr_we ? clr_mask : '0;
  assign set_eff = (mode == SMW_ACT_IRQ) ? hits : '0;
  assign fire    = (mode == SMW_ACT_RESET) && (|hits) && (pcnt_q == '0);

  always_comb begin
    if (strap_ok) status_d = (status_o & ~clr_eff) | set_eff;
    else          status_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_o <= '0;
      irq_o    <= 1'b0;
    end else begin
      status_o <= status_d;
      irq_o    <= |status_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !strap_ok) begin
      pcnt_q  <= '0;
      pulse_o <= 1'b0;
    end else if (pcnt_q != '0) begin
      pcnt_q  <= pcnt_q - 1'b1;
      pulse_o <= (pcnt_q > PW'(1));
    end else if (fire) begin
      pcnt_q  <= PLOAD;
      pulse_o <= 1'b1;
    end
  end
endmodule

// File: rtl/sm_stall_watchdog.sv
module sm_stall_watchdog
  import smw_pkg::*;
#(
  parameter int NUM_SM       = 8,
  parameter int LIMIT_TICKS  = 5,
  parameter int PULSE_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strap_in,
  input  logic              cfg_enable,
  input  logic              cfg_mode,
  input  logic              status_clr_we,
  input  logic [NUM_SM-1:0] status_clr_mask,
  input  logic              tick,
  input  logic [NUM_SM-1:0] busy,
  output logic              reset_pulse_o,
  output logic              irq_o,
  output logic [NUM_SM-1:0] stuck_status_o
);
  logic              strap_ok;
  logic              arm;
  logic [NUM_SM-1:0] hits;

  smw_strap_latch u_strap (
    .clk      (clk),
    .rst      (rst),
    .strap_in (strap_in),
    .strap_ok (strap_ok)
  );

  assign arm = strap_ok && cfg_enable;

  for (genvar g = 0; g < NUM_SM; g++) begin : g_cnt
    smw_stall_counter #(.LIMIT_TICKS(LIMIT_TICKS)) u_cnt (
      .clk   (clk),
      .rst   (rst),
      .arm   (arm),
      .clear (reset_pulse_o),
      .busy  (busy[g]),
      .tick  (tick),
      .hit   (hits[g])
    );
  end

  smw_action_unit #(.NUM_SM(NUM_SM), .PULSE_CYCLES(PULSE_CYCLES)) u_act (
    .clk      (clk),
    .rst      (rst),
    .strap_ok (strap_ok),
    .mode     (smw_action_e'(cfg_mode)),
    .hits     (hits),
    .clr_we   (status_clr_we),
    .clr_mask (status_clr_mask),
    .status_o (stuck_status_o),
    .irq_o    (irq_o),
    .pulse_o  (reset_pulse_o)
  );
endmodule

// File: rtl/smw_checker.sv
module smw_checker #(
  parameter int NUM_SM       = 8,
  parameter int PULSE_CYCLES = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              strap_in,
  input logic              cfg_enable,
  input logic              cfg_mode,
  input logic              status_clr_we,
  input logic [NUM_SM-1:0] status_clr_mask,
  input logic              reset_pulse_o,
  input logic              irq_o,
  input logic [NUM_SM-1:0] stuck_status_o
);
  localparam int LW = $clog2(PULSE_CYCLES + 2);

  logic          rst_d   = 1'b0;
  logic [1:0]    rlen    = 2'd0;
  logic          hi_seen = 1'b0;
  logic [LW-1:0] plen    = '0;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst && !rst_d) begin
      rlen    <= 2'd1;
      hi_seen <= strap_in;
    end else if (rst) begin
      rlen    <= (rlen == 2'd3) ? 2'd3 : rlen + 2'd1;
      hi_seen <= hi_seen | strap_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !reset_pulse_o) plen <= '0;
    else if (plen != LW'(PULSE_CYCLES + 1)) plen <= plen + 1'b1;
  end

  // R2: strap low throughout a long enough reset keeps every output quiet
  p_strap_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (rlen == 2'd3 && !hi_seen) |-> (!irq_o && !reset_pulse_o && stuck_status_o == '0));

  // R3: nothing is detected unless the software enable was set
  p_enable_gate_r3: assert property (@(posedge clk) disable iff (rst)
    ($rose(reset_pulse_o) || (|(stuck_status_o & ~$past(stuck_status_o)))) |-> $past(cfg_enable, 2));

  // R6: interrupt follows the status word
  p_irq_tracks_r6: assert property (@(posedge clk) disable iff (rst)
    irq_o == (|stuck_status_o));

  // R7: a status bit only drops through a clear write on that bit
  p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (($past(stuck_status_o) & ~($past(status_clr_we) ? $past(status_clr_mask) : '0)
      & ~stuck_status_o) == '0));

  // R9: status bits rise only in interrupt mode
  p_status_mode_r9: assert property (@(posedge clk) disable iff (rst)
    (|(stuck_status_o & ~$past(stuck_status_o))) |-> !$past(cfg_mode));

  // R9: a pulse starts only in reset mode
  p_pulse_mode_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(reset_pulse_o) |-> $past(cfg_mode));

  // R9: pulse never outlasts its width
  p_pulse_max_r9: assert property (@(posedge clk) disable iff (rst)
    reset_pulse_o |-> (plen < LW'(PULSE_CYCLES)));

  // R9: a pulse that ends has lasted exactly its width
  p_pulse_len_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(reset_pulse_o) |-> (plen == LW'(PULSE_CYCLES)));
endmodule

bind sm_stall_watchdog smw_checker #(.NUM_SM(NUM_SM), .PULSE_CYCLES(PULSE_CYCLES)) u_chk (
  .clk             (clk),
  .rst             (rst),
  .strap_in        (strap_in),
  .cfg_enable      (cfg_enable),
  .cfg_mode        (cfg_mode),
  .status_clr_we   (status_clr_we),
  .status_clr_mask (status_clr_mask),
  .reset_pulse_o   (reset_pulse_o),
  .irq_o           (irq_o),
  .stuck_status_o  (stuck_status_o)
);

// File: tb/sim_sm_stall_watchdog.sv
`timescale 1ns/1ps
module sim_sm_stall_watchdog;
  localparam int N   = 4;
  localparam int LIM = 3;
  localparam int PW  = 3;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         strap_in = 1'b1;
  logic         cfg_enable = 1'b0;
  logic         cfg_mode = 1'b0;
  logic         status_clr_we = 1'b0;
  logic [N-1:0] status_clr_mask = '0;
  logic         tick = 1'b0;
  logic [N-1:0] busy = '0;
  logic         reset_pulse_o;
  logic         irq_o;
  logic [N-1:0] stuck_status_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sm_stall_watchdog #(.NUM_SM(N), .LIMIT_TICKS(LIM), .PULSE_CYCLES(PW)) u0 (
    .clk(clk), .rst(rst), .strap_in(strap_in), .cfg_enable(cfg_enable),
    .cfg_mode(cfg_mode), .status_clr_we(status_clr_we),
    .status_clr_mask(status_clr_mask), .tick(tick), .busy(busy),
    .reset_pulse_o(reset_pulse_o), .irq_o(irq_o), .stuck_status_o(stuck_status_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply_reset(input logic strap);
    @(negedge clk);
    rst = 1'b1; strap_in = strap; busy = '0; tick = 1'b0;
    cfg_enable = 1'b0; cfg_mode = 1'b0; status_clr_we = 1'b0; status_clr_mask = '0;
    repeat (6) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic all_quiet(input string req);
    chk(req, {29'd0, reset_pulse_o, irq_o, |stuck_status_o}, 32'd0);
  endtask

  task automatic pulse_len(output int len);
    len = 0;
    while (reset_pulse_o && len < 50) begin
      len++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset_state();
    apply_reset(1'b1);
    all_quiet("R1 reset state");
  endtask

  task automatic t_strap_low();
    apply_reset(1'b0);
    strap_in = 1'b1; cfg_enable = 1'b1; busy = '1;
    ticks(LIM + 3);
    all_quiet("R1/R2 strap low, irq mode");
    cfg_mode = 1'b1;
    busy = '0; @(negedge clk); busy = '1;
    ticks(LIM + 3);
    all_quiet("R2 strap low, reset mode");
  endtask

  task automatic t_enable_off();
    apply_reset(1'b1);
    busy = 4'b0100;
    ticks(LIM + 3);
    all_quiet("R3 enable off");
    cfg_enable = 1'b1;
    ticks(LIM);
    all_quiet("R3 full count needed after enable");
    ticks(1);
    chk("R3 detect after enable", {28'd0, stuck_status_o}, 32'h4);
  endtask

  task automatic t_threshold();
    apply_reset(1'b1);
    strap_in = 1'b0;
    cfg_enable = 1'b1; busy = 4'b0010;
    ticks(LIM);
    all_quiet("R4 no detect at limit");
    tick = 1'b1; @(negedge clk); tick = 1'b0;
    all_quiet("R4 one edge after tick");
    @(negedge clk);
    chk("R1/R6 status after limit+1", {28'd0, stuck_status_o}, 32'h2);
    chk("R6 irq", {31'd0, irq_o}, 32'd1);
  endtask

  task automatic t_interrupted();
    apply_reset(1'b1);
    cfg_enable = 1'b1; busy = 4'b0001;
    ticks(LIM);
    busy = '0; @(negedge clk); busy = 4'b0001;
    ticks(LIM);
    all_quiet("R5 count restarted");
    ticks(1);
    chk("R5 detect after fresh stretch", {28'd0, stuck_status_o}, 32'h1);
  endtask

  task automatic t_sticky();
    apply_reset(1'b1);
    cfg_enable = 1'b1; busy = 4'b1000;
    ticks(LIM);
    tick = 1'b1; @(negedge clk); tick = 1'b0;
    status_clr_we = 1'b1; status_clr_mask = 4'b1000;
    @(negedge clk);
    status_clr_we = 1'b0; status_clr_mask = '0;
    chk("R7 set wins over clear", {28'd0, stuck_status_o}, 32'h8);
    ticks(2);
    chk("R7 sticky", {28'd0, stuck_status_o}, 32'h8);
    status_clr_we = 1'b1; status_clr_mask = 4'b0111;
    @(negedge clk);
    status_clr_we = 1'b0; status_clr_mask = '0;
    chk("R7 mask zero keeps bit", {28'd0, stuck_status_o}, 32'h8);
    status_clr_we = 1'b1; status_clr_mask = 4'b1000;
    @(negedge clk);
    status_clr_we = 1'b0; status_clr_mask = '0;
    chk("R7 cleared", {27'd0, irq_o, stuck_status_o}, 32'h0);
    ticks(LIM + 2);
    all_quiet("R8 no second detection in one stretch");
    busy = '0; @(negedge clk); busy = 4'b1000;
    ticks(LIM + 1);
    chk("R8 new stretch detects", {28'd0, stuck_status_o}, 32'h8);
  endtask

  task automatic t_reset_mode();
    int len;
    apply_reset(1'b1);
    cfg_enable = 1'b1; cfg_mode = 1'b1; busy = 4'b0100;
    ticks(LIM);
    all_quiet("R9 no pulse at limit");
    ticks(1);
    pulse_len(len);
    chk("R9 pulse width", len, PW);
    chk("R9 status untouched", {27'd0, irq_o, stuck_status_o}, 32'h0);
    ticks(LIM);
    all_quiet("R10 counters restarted after pulse");
    ticks(1);
    chk("R10 second pulse", {31'd0, reset_pulse_o}, 32'd1);
    pulse_len(len);
    chk("R10 second pulse width", len, PW);
  endtask

  task automatic t_two();
    apply_reset(1'b1);
    cfg_enable = 1'b1; busy = 4'b1001;
    ticks(LIM + 1);
    chk("R11 both recorded", {28'd0, stuck_status_o}, 32'h9);
    status_clr_we = 1'b1; status_clr_mask = 4'b0001;
    @(negedge clk);
    status_clr_we = 1'b0; status_clr_mask = '0;
    chk("R11 independent clear", {27'd0, irq_o, stuck_status_o}, 32'h18);
  endtask

  initial begin
    t_reset_state();
    t_strap_low();
    t_enable_off();
    t_threshold();
    t_interrupted();
    t_sticky();
    t_reset_mode();
    t_two();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule